// File: doc/BRIEF.md
# Scattered-Bit 64-Source Interrupt Controller

This block collects up to 64 internal interrupt lines, each with its own sense selection (active-low level, active-high level, falling edge, rising edge), and presents their state through a small memory-mapped register set. Mask and pending state are split over a "high" and a "low" 32-bit word. Source numbers land on register bits through a fixed, irregular placement rather than a linear one, so software must use the same placement to touch a given source.

A vector register reports the lowest-numbered source that is both pending and enabled, as a 6-bit code in its top bits; a code of zero means nothing is active. The interrupt output is raised whenever any enabled source is pending. Edge-sensed pending bits are sticky and are cleared by writing ones to the pending words. Two priority words and a configuration word are provided as plain storage with fixed reset values.

Top module: `scatter_irq_ctrl`

## Requirements
- R1: Source placement. Sources 1..15 sit in the high word at bit 16-n; sources 16..18 in the low word at bit 18-n; sources 19..30 in the low word at bit 33-n; sources 32..47 in the high word at bit 63-n; sources 48..63 in the low word at bit n-32. The same placement applies to mask and pending words.
- R2: A mask bit of 1 enables its source; a mask bit of 0 keeps the source out of the vector and the interrupt output, while its pending bit is still recorded and readable.
- R3: Writing a pending word clears every edge-sensed pending bit written as 1 and leaves bits written as 0 unchanged.
- R4: The vector word (address 4) holds in bits 31:26 the lowest source number that is pending and enabled, bits 25:0 read 0, and the whole word reads 0 when no enabled source is pending; writes to it have no effect.
- R5: `irq_o` is high exactly when at least one enabled source is pending.
- R6: Sense codes are 0 active-low level, 1 active-high level, 2 falling edge, 3 rising edge. Sense words at addresses 8..11 each hold 16 sources (word 8+k covers sources 16k..16k+15), source 16k+i in bits 2i+1:2i. Edge-sensed pending bits stay set until cleared.
- R7: A level-sensed pending bit follows the synchronized input: set while the input is at its active level (a write-1 clear does not remove it), cleared once the input leaves that level.
- R8: With the default two synchronizer stages, an input edge applied before clock edge k shows as pending (and on `irq_o` when enabled) after edge k+2, not after edge k+1.
- R9: After reset both mask words, both pending words and the configuration word read 0, both priority words read 0x05309770, and every sense field reads 1 (sense words 0x55555555).
- R10: Sources 0 and 31 have no register bit of their own; activity on their inputs never produces pending state, vector or interrupt.
- R11: Bus: a read request (`bus_req`=1, `bus_we`=0) returns data with `bus_rvalid`=1 one cycle later; `bus_rvalid` is 0 in other cycles. Address map: 0 mask high, 1 mask low, 2 pending high, 3 pending low, 4 vector, 5 configuration, 6 priority high, 7 priority low, 8..11 sense; addresses 12..15 read 0.
- R12: The configuration and both priority words read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| src_in | input | 64 | Raw interrupt source lines, bit n is source n |
| irq_o | output | 1 | Any enabled source pending |

## Verification
An input change driven before clock edge k becomes pending after edge k+2 and reaches `irq_o` in the same cycle, since the output is combinational from the pending and mask state; the bench checks `irq_o` after edge k+1 (expecting no change) and after edge k+2. Register reads return one edge after the request, so every read task samples `bus_rdata` and `bus_rvalid` at the falling edge that follows the request edge. Other checks wait several idle cycles after input pulses before reading, which covers the three-edge path of pending state with margin.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC   = 64;
    localparam int DW     = 32;
    localparam int AW     = 4;
    localparam int CODE_W = $clog2(NSRC);

    localparam logic [DW-1:0] PRIO_RESET = 32'h0530_9770;

    typedef enum logic [1:0] {
        SENSE_LVL_LO    = 2'd0,
        SENSE_LVL_HI    = 2'd1,
        SENSE_EDGE_FALL = 2'd2,
        SENSE_EDGE_RISE = 2'd3
    } sense_e;

    typedef enum logic [AW-1:0] {
        ADR_MASK_HI = 4'd0,
        ADR_MASK_LO = 4'd1,
        ADR_PEND_HI = 4'd2,
        ADR_PEND_LO = 4'd3,
        ADR_VECTOR  = 4'd4,
        ADR_CFG     = 4'd5,
        ADR_PRIO_HI = 4'd6,
        ADR_PRIO_LO = 4'd7
    } reg_addr_e;

    typedef struct packed {
        logic       valid;
        logic       word_lo;
        logic [4:0] bitpos;
    } slot_t;

    // Irregular placement of a source number onto a register word and bit.
    function automatic slot_t src_slot(int unsigned s);
        slot_t r;
        r = '0;
        if (s == 0 || s == 31) begin
            r.valid = 1'b0;
        end else if (s < 16) begin
            r.valid = 1'b1; r.word_lo = 1'b0; r.bitpos = 5'(16 - s);
        end else if (s < 19) begin
            r.valid = 1'b1; r.word_lo = 1'b1; r.bitpos = 5'(18 - s);
        end else if (s < 31) begin
            r.valid = 1'b1; r.word_lo = 1'b1; r.bitpos = 5'(33 - s);
        end else if (s < 48) begin
            r.valid = 1'b1; r.word_lo = 1'b0; r.bitpos = 5'(63 - s);
        end else begin
            r.valid = 1'b1; r.word_lo = 1'b1; r.bitpos = 5'(s - 32);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_sense_unit.sv
module irqc_sense_unit
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   raw_i,
    input  sense_e sense_i,
    input  logic   clr_i,
    output logic   pend_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;
    logic                   lvl;
    logic                   rise;
    logic                   fall;
    logic                   pend_q;

    assign lvl  = chain_q[SYNC_STAGES-1];
    assign rise = lvl & ~last_q;
    assign fall = ~lvl & last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
            last_q  <= lvl;
            unique case (sense_i)
                SENSE_LVL_LO:    pend_q <= ~lvl;
                SENSE_LVL_HI:    pend_q <= lvl;
                SENSE_EDGE_FALL: pend_q <= (pend_q & ~clr_i) | fall;
                SENSE_EDGE_RISE: pend_q <= (pend_q & ~clr_i) | rise;
                default:         pend_q <= 1'b0;
            endcase
        end
    end

    assign pend_o = pend_q;

    // R6: an edge-sensed pending bit holds unless a clear arrives
    a_r6_edge_sticky: assert property (@(posedge clk) disable iff (rst)
        (sense_i[1] && pend_o && !clr_i) |=> pend_o);

    // R7: active-high level source drops when the synchronized input is low
    a_r7_level_drop: assert property (@(posedge clk) disable iff (rst)
        (sense_i == SENSE_LVL_HI && !lvl) |=> !pend_o);

endmodule

// File: rtl/irqc_first_set.sv
module irqc_first_set #(
    parameter int W  = 64,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  req_i,
    output logic [CW-1:0] code_o
);
    // Lowest index wins; index 0 cannot be reported (code 0 means none).
    always_comb begin
        code_o = '0;
        for (int i = W - 1; i >= 1; i--) begin
            if (req_i[i]) code_o = CW'(i);
        end
    end
endmodule

// File: rtl/scatter_irq_ctrl.sv
module scatter_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_req,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_rvalid,
    input  logic [NSRC-1:0] src_in,
    output logic            irq_o
);
    localparam int FIELDS_PER_WORD = DW / 2;
    localparam int SENSE_WORDS     = NSRC / FIELDS_PER_WORD;

    logic          wr_en;
    logic          rd_en;
    logic [DW-1:0] mask_hi_q;
    logic [DW-1:0] mask_lo_q;
    logic [DW-1:0] cfg_q;
    logic [DW-1:0] prio_hi_q;
    logic [DW-1:0] prio_lo_q;
    sense_e        sense_q [NSRC];

    logic [NSRC-1:0]   pend_src;
    logic [NSRC-1:0]   mask_src;
    logic [NSRC-1:0]   clr_src;
    logic [NSRC-1:0]   req_src;
    logic [CODE_W-1:0] vec_code;
    logic [DW-1:0]     pend_hi_w;
    logic [DW-1:0]     pend_lo_w;
    logic [DW-1:0]     rd_word;
    logic              sense_sel;
    logic [1:0]        sense_idx;

    assign wr_en     = bus_req & bus_we;
    assign rd_en     = bus_req & ~bus_we;
    assign sense_sel = (bus_addr[AW-1:AW-2] == 2'b10);
    assign sense_idx = bus_addr[1:0];

    // Register storage
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_hi_q <= '0;
            mask_lo_q <= '0;
            cfg_q     <= '0;
            prio_hi_q <= PRIO_RESET;
            prio_lo_q <= PRIO_RESET;
            for (int s = 0; s < NSRC; s++) sense_q[s] <= SENSE_LVL_HI;
        end else if (wr_en) begin
            case (bus_addr)
                4'(ADR_MASK_HI): mask_hi_q <= bus_wdata;
                4'(ADR_MASK_LO): mask_lo_q <= bus_wdata;
                4'(ADR_CFG):     cfg_q     <= bus_wdata;
                4'(ADR_PRIO_HI): prio_hi_q <= bus_wdata;
                4'(ADR_PRIO_LO): prio_lo_q <= bus_wdata;
                default: begin
                    if (sense_sel) begin
                        for (int i = 0; i < FIELDS_PER_WORD; i++) begin
                            sense_q[int'(sense_idx) * FIELDS_PER_WORD + i]
                                <= sense_e'(bus_wdata[2*i +: 2]);
                        end
                    end
                end
            endcase
        end
    end

    // Per-source slice: live sources get a sense unit, reserved ones are tied off
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam slot_t SL = src_slot(s);
        if (SL.valid) begin : g_live
            assign mask_src[s] = SL.word_lo ? mask_lo_q[SL.bitpos] : mask_hi_q[SL.bitpos];
            assign clr_src[s]  = wr_en
                               && (bus_addr == (SL.word_lo ? 4'(ADR_PEND_LO) : 4'(ADR_PEND_HI)))
                               && bus_wdata[SL.bitpos];
            irqc_sense_unit #(.SYNC_STAGES(SYNC_STAGES)) u_unit (
                .clk     (clk),
                .rst     (rst),
                .raw_i   (src_in[s]),
                .sense_i (sense_q[s]),
                .clr_i   (clr_src[s]),
                .pend_o  (pend_src[s])
            );
        end else begin : g_rsvd
            logic rsvd_unused;
            assign rsvd_unused = src_in[s];
            assign mask_src[s] = 1'b0;
            assign clr_src[s]  = 1'b0;
            assign pend_src[s] = 1'b0;
        end
    end

    // Gather per-source pending into the two scattered words
    always_comb begin
        slot_t sl;
        pend_hi_w = '0;
        pend_lo_w = '0;
        for (int s = 0; s < NSRC; s++) begin
            sl = src_slot(s);
            if (sl.valid) begin
                if (sl.word_lo) pend_lo_w[sl.bitpos] = pend_src[s];
                else            pend_hi_w[sl.bitpos] = pend_src[s];
            end
        end
    end

    assign req_src = pend_src & mask_src;

    irqc_first_set #(.W(NSRC), .CW(CODE_W)) u_enc (
        .req_i  (req_src),
        .code_o (vec_code)
    );

    assign irq_o = |req_src;

    // Read mux
    always_comb begin
        rd_word = '0;
        case (bus_addr)
            4'(ADR_MASK_HI): rd_word = mask_hi_q;
            4'(ADR_MASK_LO): rd_word = mask_lo_q;
            4'(ADR_PEND_HI): rd_word = pend_hi_w;
            4'(ADR_PEND_LO): rd_word = pend_lo_w;
            4'(ADR_VECTOR):  rd_word = {vec_code, {(DW-CODE_W){1'b0}}};
            4'(ADR_CFG):     rd_word = cfg_q;
            4'(ADR_PRIO_HI): rd_word = prio_hi_q;
            4'(ADR_PRIO_LO): rd_word = prio_lo_q;
            default: begin
                if (sense_sel && int'(sense_idx) < SENSE_WORDS) begin
                    for (int i = 0; i < FIELDS_PER_WORD; i++) begin
                        rd_word[2*i +: 2] = sense_q[int'(sense_idx) * FIELDS_PER_WORD + i];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_en;
            if (rd_en) bus_rdata <= rd_word;
        end
    end

    // R11: read data valid exactly one cycle after a read request
    a_r11_rvalid: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> bus_rvalid);
    a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !bus_rvalid);

    // R5: interrupt output agrees with the encoder result
    a_r5_irq_vec: assert property (@(posedge clk) disable iff (rst)
        irq_o == (vec_code != '0));

    // R4: a reported code points at an enabled pending source
    a_r4_hit: assert property (@(posedge clk) disable iff (rst)
        (vec_code != '0) |-> (pend_src[vec_code] && mask_src[vec_code]));

    // R2: mask write lands in the mask word
    a_r2_mask_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr == 4'(ADR_MASK_HI)) |=> (mask_hi_q == $past(bus_wdata)));

endmodule

// File: tb/scatter_irq_ctrl_tb.sv
`timescale 1ns/1ps
module scatter_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_req;
    logic        bus_we;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [63:0] src_in;
    logic        irq_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    scatter_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .src_in(src_in), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
        chk("R11 rvalid after read", {31'b0, bus_rvalid}, 32'd1);
    endtask

    // Expected placement, from R1
    function automatic logic [32:0] place(input int s);
        if (s < 16)      return {1'b0, 32'(1) << (16 - s)};
        else if (s < 19) return {1'b1, 32'(1) << (18 - s)};
        else if (s < 31) return {1'b1, 32'(1) << (33 - s)};
        else if (s < 48) return {1'b0, 32'(1) << (63 - s)};
        else             return {1'b1, 32'(1) << (s - 32)};
    endfunction

    task automatic pulse(input int s);
        src_in[s] = 1'b1; idle(3);
        src_in[s] = 1'b0; idle(4);
    endtask

    task automatic all_rise();
        for (int k = 0; k < 4; k++) wr(4'(8 + k), 32'hFFFF_FFFF);
    endtask

    task automatic clear_all();
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd3, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd0, d); chk("R9 mask hi", d, 0);
        rd(4'd1, d); chk("R9 mask lo", d, 0);
        rd(4'd2, d); chk("R9 pend hi", d, 0);
        rd(4'd3, d); chk("R9 pend lo", d, 0);
        rd(4'd4, d); chk("R9 vector", d, 0);
        rd(4'd5, d); chk("R9 cfg", d, 0);
        rd(4'd6, d); chk("R9 prio hi", d, 32'h0530_9770);
        rd(4'd7, d); chk("R9 prio lo", d, 32'h0530_9770);
        for (int k = 0; k < 4; k++) begin
            rd(4'(8 + k), d); chk("R9 sense word", d, 32'h5555_5555);
        end
        chk("R9 irq", {31'b0, irq_o}, 0);
    endtask

    task automatic t_placement();
        logic [31:0] h, l;
        logic [32:0] p;
        all_rise();
        for (int s = 1; s < 64; s++) begin
            if (s != 31) begin
                pulse(s);
                p = place(s);
                rd(4'd2, h); rd(4'd3, l);
                chk($sformatf("R1 src %0d pend hi", s), h, p[32] ? 32'd0 : p[31:0]);
                chk($sformatf("R1 src %0d pend lo", s), l, p[32] ? p[31:0] : 32'd0);
                clear_all();
            end
        end
    endtask

    task automatic t_mask_vector();
        logic [31:0] d;
        pulse(40); pulse(5); pulse(60);
        rd(4'd4, d); chk("R2 masked vector", d, 0);
        chk("R2 masked irq", {31'b0, irq_o}, 0);
        rd(4'd2, d); chk("R2 pending kept", d, (32'd1 << 23) | (32'd1 << 11));
        wr(4'd0, 32'd1 << 23);
        rd(4'd4, d); chk("R4 vector src40", d, 32'd40 << 26);
        chk("R5 irq on", {31'b0, irq_o}, 1);
        wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd4, d); chk("R4 lowest wins", d, 32'd5 << 26);
        wr(4'd2, 32'd1 << 11);
        rd(4'd4, d); chk("R4 next after clear", d, 32'd40 << 26);
        wr(4'd0, 32'd0);
        rd(4'd4, d); chk("R4 low word source", d, 32'd60 << 26);
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd4, d); chk("R4 vector write ignored", d, 32'd60 << 26);
        clear_all();
        chk("R5 irq off", {31'b0, irq_o}, 0);
        rd(4'd4, d); chk("R4 none pending", d, 0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        pulse(20); pulse(21);
        wr(4'd3, 32'd1 << 13);
        rd(4'd3, d); chk("R3 only written bit cleared", d, 32'd1 << 12);
        clear_all();
        rd(4'd3, d); chk("R3 all cleared", d, 0);
    endtask

    task automatic t_sense();
        logic [31:0] d;
        // R7/R6: source 50 active-high level (word 11, field bits 5:4 = 1)
        wr(4'd11, 32'hFFFF_FFDF);
        src_in[50] = 1'b1; idle(4);
        rd(4'd3, d); chk("R7 level high pending", d, 32'd1 << 18);
        wr(4'd3, 32'd1 << 18);
        rd(4'd3, d); chk("R7 clear has no effect while asserted", d, 32'd1 << 18);
        src_in[50] = 1'b0; idle(4);
        rd(4'd3, d); chk("R7 level released", d, 0);
        // R6: source 10 active-low level (word 8, bits 21:20 = 0)
        wr(4'd8, 32'hFFCF_FFFF);
        idle(2);
        rd(4'd2, d); chk("R6 level low pending", d, 32'd1 << 6);
        src_in[10] = 1'b1; idle(4);
        rd(4'd2, d); chk("R6 level low released", d, 0);
        // R6: source 12 falling edge (word 8, bits 25:24 = 2)
        wr(4'd8, 32'hFEFF_FFFF);
        src_in[12] = 1'b1; idle(5);
        rd(4'd2, d); chk("R6 falling ignores rise", d, 0);
        src_in[12] = 1'b0; idle(5);
        rd(4'd2, d); chk("R6 falling edge pending", d, 32'd1 << 4);
        idle(3);
        rd(4'd2, d); chk("R6 edge pending sticky", d, 32'd1 << 4);
        rd(4'd8, d); chk("R6 sense readback", d, 32'hFEFF_FFFF);
        all_rise();
        src_in[10] = 1'b0; idle(4);
        clear_all();
    endtask

    task automatic t_latency();
        wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'hFFFF_FFFF);
        src_in[33] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R8 not yet after two edges", {31'b0, irq_o}, 0);
        @(posedge clk); @(negedge clk);
        chk("R8 pending after third edge", {31'b0, irq_o}, 1);
        src_in[33] = 1'b0; idle(4);
        clear_all();
        chk("R8 cleared", {31'b0, irq_o}, 0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        pulse(0); pulse(31);
        rd(4'd2, d); chk("R10 reserved hi", d, 0);
        rd(4'd3, d); chk("R10 reserved lo", d, 0);
        chk("R10 reserved irq", {31'b0, irq_o}, 0);
        rd(4'd4, d); chk("R10 reserved vector", d, 0);
    endtask

    task automatic t_bus();
        logic [31:0] d;
        wr(4'd5, 32'hA5A5_0F0F);
        rd(4'd5, d); chk("R12 cfg readback", d, 32'hA5A5_0F0F);
        wr(4'd6, 32'h1234_5678);
        rd(4'd6, d); chk("R12 prio hi readback", d, 32'h1234_5678);
        wr(4'd7, 32'h8765_4321);
        rd(4'd7, d); chk("R12 prio lo readback", d, 32'h8765_4321);
        rd(4'd12, d); chk("R11 unused address", d, 0);
        idle(1);
        chk("R11 no rvalid without read", {31'b0, bus_rvalid}, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0;
        bus_wdata = '0; src_in = '0;
        idle(4);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_placement();
        t_mask_vector();
        t_w1c();
        t_sense();
        t_latency();
        t_reserved();
        t_bus();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule